// File: doc/BRIEF.md
# Shader Program Fetch Sequencer

This block keeps the instruction store and the operand-swizzle table of a programmable vertex stage, and walks through the program on behalf of an arithmetic execution unit that sits beside it. The host fills each store with a simple streaming protocol. A restart register sets the store's write pointer back to word zero. Each write to any of eight equivalent data aliases then places one word and moves the pointer on by one. A 16-bit entry register selects the first instruction word.

A start pulse launches a run. Every cycle the sequencer looks only at the opcode field of the current word. Ordinary instructions go out on the fetch port, together with their address and the swizzle pattern they select, and the program counter moves on by one. Subroutine entry and return are handled internally with an eight-deep return-address stack. A return with nothing on the stack marks the end of the program. A subroutine entry on a full stack aborts the run and raises a sticky error. Host loads and further start pulses are ignored while a run is in progress.

Top module: `shader_fetch_seq`

## Requirements
- R1: While reset is held, and after it is released with no stimulus applied, `busy`, `done`, `stack_ovf` and `fetch_valid` are all low.
- R2: A write to select 0x01 sets the program write pointer to zero. Each write to any select in 0x08..0x0F stores `host_data` at the pointer and increments it.
- R3: The swizzle table follows the same rule, with restart at select 0x02 and data aliases at 0x10..0x17. `fetch_swz` shows the table entry indexed by `fetch_word[4:0]`.
- R4: A write to select 0x00 loads the entry register from `host_data[15:0]`. A start pulse while idle makes `busy` high on the next cycle, with the fetch address equal to the low 10 bits of the entry register.
- R5: The opcode is `fetch_word[31:26]`. A word whose opcode is not one of 0x21, 0x22 or 0x24 is presented with `fetch_valid` high for one cycle, and the next address is the current address plus one.
- R6: Opcode 0x22 (flush) is not presented on the fetch port. The address simply advances by one.
- R7: Opcode 0x24 (call) pushes its own address onto the return stack and jumps to `fetch_word[21:10]`, a word offset from the start of the program store. The address is not incremented in that step, and the word is not presented.
- R8: Opcode 0x21 (return) with a non-empty stack pops the saved address and resumes at that address plus one. With an empty stack it ends the run: `busy` falls and `done` is high for exactly one cycle.
- R9: The return stack holds 8 addresses and is emptied at every accepted start. A call made while 8 addresses are stacked sets `stack_ovf` and ends the run with a `done` pulse. `stack_ovf` stays set until the next accepted start clears it.
- R10: Each store holds 1024 words. Data writes made after the pointer has reached 1024 are discarded and do not wrap to word zero.
- R11: While `busy` is high, host writes to any select and start pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 5 | Host register select |
| host_data | input | 32 | Host write data |
| start | input | 1 | Run launch pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when a run ends |
| stack_ovf | output | 1 | Sticky return-stack overflow error |
| fetch_valid | output | 1 | Instruction presented to the execution unit |
| fetch_pc | output | 10 | Word address of the presented instruction |
| fetch_word | output | 32 | Instruction word at the current address |
| fetch_swz | output | 32 | Swizzle pattern selected by the instruction |

## Verification
The bench targets the return path. It checks that control resumes one word past the call; a design that resumed at the call itself would loop forever and trip the watchdog. Nesting exactly eight calls must succeed and a ninth must abort with the error set, so an off-by-one in the full test either flags a legal program or silently corrupts the stack. Flush and call words must never reach the fetch port, which the scoreboard would see as unexpected items. The bench also sends host writes and a second start during a run, and fills the program store one word past its end. A design that obeyed either would damage word zero or the entry offset, and the rerun that follows would fetch the wrong words.

// File: rtl/shader_seq_pkg.sv
package shader_seq_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned OPC_LSB   = 26;
  localparam int unsigned TGT_LSB   = 10;
  localparam int unsigned SWZ_IDX_W = 5;

  localparam logic [5:0] OPC_RET  = 6'h21;
  localparam logic [5:0] OPC_FLS  = 6'h22;
  localparam logic [5:0] OPC_CALL = 6'h24;

  localparam logic [4:0] SEL_ENTRY      = 5'h00;
  localparam logic [4:0] SEL_PROG_BEGIN = 5'h01;
  localparam logic [4:0] SEL_SWZ_BEGIN  = 5'h02;
  localparam logic [1:0] GRP_PROG_DATA  = 2'b01;
  localparam logic [1:0] GRP_SWZ_DATA   = 2'b10;
endpackage

// File: rtl/sfs_word_store.sv
module sfs_word_store #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          restart,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [PW-1:0] ptr_q, ptr_d;
  logic [W-1:0]  mem [DEPTH];
  logic          room, we;

  assign room = (ptr_q < PW'(DEPTH));
  assign we   = accept && push && !restart && room;

  always_comb begin
    ptr_d = ptr_q;
    if (accept && restart)  ptr_d = '0;
    else if (we)            ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (accept) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk) begin
    if (we) mem[ptr_q[AW-1:0]] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sfs_ret_stack.sv
module sfs_ret_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 10,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top_addr,
  output logic          empty,
  output logic          full
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] slot [DEPTH];
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full && !clear;
  assign do_pop  = pop && !empty && !clear;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)        cnt_d = '0;
    else if (do_push) cnt_d = cnt_q + 1'b1;
    else if (do_pop)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (do_push) slot[IW'(cnt_q)] <= push_addr;
  end

  assign top_addr = slot[IW'(cnt_q - 1'b1)];
endmodule

// File: rtl/sfs_seq_ctrl.sv
module sfs_seq_ctrl
  import shader_seq_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     entry,
  input  logic [WORD_W-1:0] instr,
  input  logic              stk_empty,
  input  logic              stk_full,
  input  logic [AW-1:0]     stk_top,
  output logic              busy,
  output logic              done,
  output logic              ovf,
  output logic [AW-1:0]     pc,
  output logic              stk_clear,
  output logic              stk_push,
  output logic              stk_pop,
  output logic              fetch_valid
);
  logic          busy_q, busy_d, done_q, done_d, ovf_q, ovf_d;
  logic [AW-1:0] pc_q, pc_d;
  logic          pc_en;
  logic [5:0]    opc;
  logic          is_call, is_ret, is_fls;

  assign opc     = instr[OPC_LSB +: 6];
  assign is_call = (opc == OPC_CALL);
  assign is_ret  = (opc == OPC_RET);
  assign is_fls  = (opc == OPC_FLS);

  always_comb begin
    busy_d    = busy_q;
    done_d    = 1'b0;
    ovf_d     = ovf_q;
    pc_d      = pc_q;
    stk_clear = 1'b0;
    stk_push  = 1'b0;
    stk_pop   = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d    = 1'b1;
        ovf_d     = 1'b0;
        pc_d      = entry;
        stk_clear = 1'b1;
      end
    end else if (is_call) begin
      if (stk_full) begin
        ovf_d  = 1'b1;
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        stk_push = 1'b1;
        pc_d     = instr[TGT_LSB +: AW];
      end
    end else if (is_ret) begin
      if (stk_empty) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        stk_pop = 1'b1;
        pc_d    = AW'(stk_top + 1'b1);
      end
    end else begin
      pc_d = AW'(pc_q + 1'b1);
    end
  end

  assign pc_en = busy_q || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      pc_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      ovf_q  <= ovf_d;
      if (pc_en) pc_q <= pc_d;
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign ovf         = ovf_q;
  assign pc          = pc_q;
  assign fetch_valid = busy_q && !is_call && !is_ret && !is_fls;
endmodule

// File: rtl/shader_fetch_seq.sv
module shader_fetch_seq
  import shader_seq_pkg::*;
#(
  parameter int unsigned PROG_DEPTH  = 1024,
  parameter int unsigned SWZ_DEPTH   = 1024,
  parameter int unsigned STACK_DEPTH = 8,
  localparam int unsigned PAW = $clog2(PROG_DEPTH),
  localparam int unsigned SAW = $clog2(SWZ_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [4:0]        host_sel,
  input  logic [WORD_W-1:0] host_data,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              stack_ovf,
  output logic              fetch_valid,
  output logic [PAW-1:0]    fetch_pc,
  output logic [WORD_W-1:0] fetch_word,
  output logic [WORD_W-1:0] fetch_swz
);
  logic          idle;
  logic          prog_restart, prog_push, swz_restart, swz_push, entry_en;
  logic [15:0]   entry_q;
  logic [SAW-1:0] swz_idx;
  logic          stk_clear, stk_push, stk_pop, stk_empty, stk_full;
  logic [PAW-1:0] stk_top;

  assign idle         = !busy;
  assign prog_restart = host_wr && (host_sel == SEL_PROG_BEGIN);
  assign prog_push    = host_wr && (host_sel[4:3] == GRP_PROG_DATA);
  assign swz_restart  = host_wr && (host_sel == SEL_SWZ_BEGIN);
  assign swz_push     = host_wr && (host_sel[4:3] == GRP_SWZ_DATA);
  assign entry_en     = host_wr && idle && (host_sel == SEL_ENTRY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        entry_q <= '0;
    else if (entry_en) entry_q <= host_data[15:0];
  end

  sfs_word_store #(.DEPTH(PROG_DEPTH), .W(WORD_W)) u_prog (
    .clk, .rst_n,
    .accept (idle),
    .restart(prog_restart),
    .push   (prog_push),
    .wdata  (host_data),
    .raddr  (fetch_pc),
    .rdata  (fetch_word)
  );

  assign swz_idx = SAW'(fetch_word[SWZ_IDX_W-1:0]);

  sfs_word_store #(.DEPTH(SWZ_DEPTH), .W(WORD_W)) u_swz (
    .clk, .rst_n,
    .accept (idle),
    .restart(swz_restart),
    .push   (swz_push),
    .wdata  (host_data),
    .raddr  (swz_idx),
    .rdata  (fetch_swz)
  );

  sfs_ret_stack #(.DEPTH(STACK_DEPTH), .AW(PAW)) u_stack (
    .clk, .rst_n,
    .clear    (stk_clear),
    .push     (stk_push),
    .pop      (stk_pop),
    .push_addr(fetch_pc),
    .top_addr (stk_top),
    .empty    (stk_empty),
    .full     (stk_full)
  );

  sfs_seq_ctrl #(.AW(PAW)) u_ctrl (
    .clk, .rst_n,
    .start      (start),
    .entry      (entry_q[PAW-1:0]),
    .instr      (fetch_word),
    .stk_empty  (stk_empty),
    .stk_full   (stk_full),
    .stk_top    (stk_top),
    .busy       (busy),
    .done       (done),
    .ovf        (stack_ovf),
    .pc         (fetch_pc),
    .stk_clear  (stk_clear),
    .stk_push   (stk_push),
    .stk_pop    (stk_pop),
    .fetch_valid(fetch_valid)
  );
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker
  import shader_seq_pkg::*;
#(
  parameter int unsigned PAW = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              stack_ovf,
  input logic              fetch_valid,
  input logic [PAW-1:0]    fetch_pc,
  input logic [WORD_W-1:0] fetch_word,
  input logic [15:0]       entry_q
);
  logic [5:0] opc;
  assign opc = fetch_word[OPC_LSB +: 6];

  AST_START_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && fetch_pc == $past(entry_q[PAW-1:0]))); // R4
  AST_FETCH_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> busy); // R5
  AST_PLAIN_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> (busy && fetch_pc == PAW'($past(fetch_pc) + 1'b1))); // R5
  AST_FLOW_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (opc != OPC_CALL && opc != OPC_RET && opc != OPC_FLS)); // R6
  AST_CALL_JUMPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && opc == OPC_CALL) |=> (!busy || fetch_pc == $past(fetch_word[TGT_LSB +: PAW]))); // R7
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_ovf && !start) |=> stack_ovf); // R9
  AST_OVF_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stack_ovf) |-> done); // R9
endmodule

bind shader_fetch_seq sfs_checker #(.PAW(PAW)) u_chk (
  .clk, .rst_n, .start, .busy, .done, .stack_ovf,
  .fetch_valid, .fetch_pc, .fetch_word, .entry_q
);

// File: tb/sim_shader_fetch_seq.sv
`timescale 1ns/1ps
module sim_shader_fetch_seq;
  import shader_seq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic [4:0]  host_sel;
  logic [31:0] host_data;
  logic        start;
  logic        busy, done, stack_ovf, fetch_valid;
  logic [9:0]  fetch_pc;
  logic [31:0] fetch_word, fetch_swz;

  always #2.5 clk = ~clk;

  shader_fetch_seq u0 (.*);

  int n_chk = 0, n_fail = 0, n_done = 0, cyc = 0;
  string cur_req = "R5";
  logic [73:0] exp_q[$];
  logic [31:0] img [32];
  logic [31:0] swz_img [32];

  function automatic logic [31:0] plain(input logic [5:0] op, input logic [20:0] tag, input logic [4:0] idx);
    return {op, tag, idx};
  endfunction
  function automatic logic [31:0] callw(input logic [11:0] t);
    return {6'h24, 4'h0, t, 10'h0};
  endfunction
  localparam logic [31:0] RETW = {6'h21, 26'h0};
  localparam logic [31:0] FLSW = {6'h22, 26'h0};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [73:0] act, input logic [73:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: compares presented instructions against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (fetch_valid) begin
        if (exp_q.size() == 0)
          check(1'b0, cur_req, "unexpected fetch", {fetch_pc, fetch_word, fetch_swz}, '0);
        else begin
          logic [73:0] e;
          e = exp_q.pop_front();
          check({fetch_pc, fetch_word, fetch_swz} == e, cur_req, "fetched item",
                {fetch_pc, fetch_word, fetch_swz}, e);
        end
      end
      if (done) n_done++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      check(1'b0, "watchdog", "run did not finish", 74'(cyc), '0);
      summary();
    end
  end

  task automatic hw(input logic [4:0] s, input logic [31:0] d);
    host_wr = 1'b1; host_sel = s; host_data = d;
    @(negedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic pulse_start;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic load_prog(input int n);
    hw(SEL_PROG_BEGIN, '0);
    for (int i = 0; i < n; i++) hw(5'h08 + 5'(i % 8), img[i]);
  endtask

  task automatic expect_fetch(input logic [9:0] pc, input logic [31:0] w);
    exp_q.push_back({pc, w, swz_img[w[4:0]]});
  endtask

  task automatic wait_done(input string req);
    int d0 = n_done;
    for (int i = 0; i < 3000 && n_done == d0; i++) begin
      @(negedge clk); #1;
    end
    check(n_done == d0 + 1, req, "one done pulse per run", 74'(n_done - d0), 74'd1);
    check(exp_q.size() == 0, req, "all expected fetches seen", 74'(exp_q.size()), '0);
    exp_q.delete();
    check(busy == 1'b0, req, "idle after run", 74'(busy), '0);
  endtask

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_sel = '0; host_data = '0; start = 1'b0;
    repeat (4) @(negedge clk);
    check({busy, done, stack_ovf, fetch_valid} == 4'b0, "R1", "outputs in reset",
          74'({busy, done, stack_ovf, fetch_valid}), '0);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check({busy, done, stack_ovf, fetch_valid} == 4'b0, "R1", "outputs after reset",
          74'({busy, done, stack_ovf, fetch_valid}), '0);

    // swizzle table load through its aliases (R3)
    hw(SEL_SWZ_BEGIN, '0);
    for (int i = 0; i < 32; i++) begin
      swz_img[i] = 32'h5A00_0000 | (i * 32'h111);
      hw(5'h10 + 5'(i % 8), swz_img[i]);
    end

    // program with a call, a flush and two returns (R2 R3 R5 R6 R7 R8)
    img[0] = plain(6'h00, 21'h1, 5'd1);
    img[1] = callw(12'd5);
    img[2] = plain(6'h13, 21'h2, 5'd2);
    img[3] = RETW;
    img[4] = plain(6'h08, 21'h7, 5'd7);
    img[5] = plain(6'h08, 21'h3, 5'd3);
    img[6] = FLSW;
    img[7] = RETW;
    load_prog(8);
    hw(SEL_ENTRY, 32'h0);
    cur_req = "R2/R3/R5/R6/R7/R8";
    expect_fetch(10'd0, img[0]);
    expect_fetch(10'd5, img[5]);
    expect_fetch(10'd2, img[2]);
    pulse_start();
    check(busy == 1'b1, "R4", "busy after start", 74'(busy), 74'd1);
    wait_done("R8");
    check(stack_ovf == 1'b0, "R9", "no overflow on shallow program", 74'(stack_ovf), '0);

    // host writes and start during a run are ignored (R11)
    cur_req = "R11";
    expect_fetch(10'd0, img[0]);
    expect_fetch(10'd5, img[5]);
    expect_fetch(10'd2, img[2]);
    pulse_start();
    hw(SEL_PROG_BEGIN, '0);
    hw(5'h08, RETW);
    hw(SEL_ENTRY, 32'd5);
    pulse_start();
    wait_done("R11");
    expect_fetch(10'd0, img[0]);
    expect_fetch(10'd5, img[5]);
    expect_fetch(10'd2, img[2]);
    pulse_start();
    wait_done("R11");

    // nonzero entry offset (R4)
    cur_req = "R4";
    hw(SEL_ENTRY, 32'd2);
    expect_fetch(10'd2, img[2]);
    pulse_start();
    wait_done("R4");

    // eight nested calls succeed (R7 R9)
    for (int i = 0; i < 8; i++) begin
      img[2*i]   = callw(12'(2*i + 2));
      img[2*i+1] = RETW;
    end
    img[16] = plain(6'h13, 21'h9, 5'd4);
    img[17] = RETW;
    load_prog(18);
    hw(SEL_ENTRY, 32'd0);
    cur_req = "R7/R9";
    expect_fetch(10'd16, img[16]);
    pulse_start();
    wait_done("R7");
    check(stack_ovf == 1'b0, "R9", "eight-deep nesting allowed", 74'(stack_ovf), '0);

    // ninth nested call overflows (R9)
    img[16] = callw(12'd18);
    img[18] = plain(6'h00, 21'h5, 5'd5);
    load_prog(19);
    cur_req = "R9";
    pulse_start();
    wait_done("R9");
    check(stack_ovf == 1'b1, "R9", "overflow flagged", 74'(stack_ovf), 74'd1);
    repeat (5) @(negedge clk);
    #1;
    check(stack_ovf == 1'b1, "R9", "overflow sticky while idle", 74'(stack_ovf), 74'd1);
    hw(SEL_ENTRY, 32'd17);
    pulse_start();
    check(stack_ovf == 1'b0, "R9", "overflow cleared by start", 74'(stack_ovf), '0);
    wait_done("R9");

    // writes past the end of the program store are dropped (R10)
    hw(SEL_PROG_BEGIN, '0);
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] w;
      w = (i == 0) ? plain(6'h00, 21'h1234, 5'd6) :
          (i == 1) ? RETW : plain(6'h13, 21'(i), 5'd0);
      if (i == 0) img[0] = w;
      hw(5'h08 + 5'(i % 8), w);
    end
    hw(5'h0B, RETW);
    hw(SEL_ENTRY, 32'd0);
    cur_req = "R10";
    expect_fetch(10'd0, img[0]);
    pulse_start();
    wait_done("R10");

    summary();
  end
endmodule